// File: doc/BRIEF.md
# Falling-Edge DMA Request Acceptor

This block watches an active-low request pin for one DMA channel and turns each falling edge into exactly one data transfer. The pin is synchronized, and a low level seen while the acceptor is open is latched as a held request. After a fixed lead time the held request is cleared. The block then raises a bus request and runs one read cycle followed by one write cycle against a simple grant/done handshake.

Once a request is taken, the acceptor stays closed until the pin has been seen high again. The high check runs while the bus is busy. If the pin went high before the write cycle finished, the acceptor reopens as soon as the write completes. If it did not, the acceptor reopens only once a later high sample arrives. The channel is armed by an enable write that also loads a transfer count. It returns to idle, with a one-cycle completion pulse, when the count runs out, when software disables it, or when it is enabled with a count of zero.

Top module: `dma_req_accept`

## Requirements
- R1: On reset all outputs are 0, and while the channel is idle, lows on the pin latch nothing and raise no bus request.
- R2: An enable write (`enWrStrobe` with `enWrData`=1) with a nonzero `xferCount` makes `acceptOpen` read 1 in the cycle after the strobe.
- R3: The pin passes through a two-flop synchronizer. A low driven while `acceptOpen`=1 sets `reqHeld` on the third rising edge after the drive, and `acceptOpen` drops on that same edge.
- R4: `reqHeld` stays 1 for exactly `LEAD_CYC` (default 3) cycles. On the edge that clears it, `busReq` rises, so at least 3 cycles separate the latch from the start of the bus phase.
- R5: The bus phase goes in this order. `busReq` stays 1 with `cycWrite`=0 until `busGrant`. The read cycle (`cycWrite`=0) lasts until a `cycleDone`. The write cycle (`cycWrite`=1) lasts until the next `cycleDone`. `busReq` then drops.
- R6: If the synchronized pin is high on any edge from the start of the bus phase up to the edge that ends the write, `acceptOpen` reads 1 in the cycle after `busReq` drops.
- R7: If no such high sample occurs, `acceptOpen` stays 0 after the transfer and a pin still held low starts nothing. A later high sample reopens acceptance, and only a fresh low after that starts the next transfer.
- R8: When the transfer that exhausts the count ends, the block goes idle: `xferDone` is 1 for exactly one cycle, `acceptOpen` is 0, and further pin lows are ignored.
- R9: A disable write (`enWrStrobe` with `enWrData`=0) while active returns to idle, drops `reqHeld` and `acceptOpen`, and pulses `xferDone` for one cycle.
- R10: An enable write with `xferCount`=0 leaves the channel idle with `acceptOpen`=0 and pulses `xferDone` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqPinN | input | 1 | External DMA request pin, active low, asynchronous |
| enWrStrobe | input | 1 | One-cycle strobe of a write to the channel enable register |
| enWrData | input | 1 | Enable bit value carried by that write |
| xferCount | input | CNT_W | Number of transfers, loaded by an enable write |
| busGrant | input | 1 | Bus stub grants the requested bus |
| cycleDone | input | 1 | Bus stub finishes the current read or write cycle |
| reqHeld | output | 1 | Latched request flag |
| busReq | output | 1 | Bus request, high for the whole bus phase |
| cycWrite | output | 1 | 0 during the read cycle, 1 during the write cycle |
| acceptOpen | output | 1 | A low on the pin would be accepted now |
| xferDone | output | 1 | One-cycle pulse when the channel returns to idle |

## Verification
The bench holds the pin low straight through a transfer. A design that reopened on the end of the write alone would fire a second transfer from a single edge. It also raises the pin during the bus phase and expects acceptance back right after the write, which catches rearm logic that samples only after the bus is released and so loses one turnaround. Latch latency and lead length are checked to the exact cycle, so a missing synchronizer stage or an off-by-one lead counter shows up as a shifted `reqHeld` or `busReq` edge. Disable during the lead phase, a zero count and a withheld grant probe the exits and stalls: a stuck held request, a missing or stretched completion pulse, and a read that starts before the grant.

// File: rtl/dma_acc_pkg.sv
package dma_acc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_LEAD  = 3'd2,
    ST_GRANT = 3'd3,
    ST_READ  = 3'd4,
    ST_WRITE = 3'd5
  } accState_t;

  // Strobes from the control FSM to the datapath, all single-cycle.
  typedef struct packed {
    logic loadCnt;      // capture transfer count
    logic openAccept;   // enable write: open acceptance
    logic latchReq;     // low accepted: hold request, close acceptance
    logic leadTick;     // advance lead-time counter
    logic clrReq;       // activation: drop held request
    logic sampleHigh;   // bus phase: look for pin high
    logic reopenIfHigh; // closed and idle on bus: reopen on high sample
    logic endWrite;     // write done, more transfers remain
    logic shutdown;     // go idle and pulse completion
  } ctlStrb_t;

endpackage

// File: rtl/dma_acc_datapath.sv
module dma_acc_datapath
  import dma_acc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int LEAD_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinN,
  input  logic [CNT_W-1:0] cntIn,
  input  ctlStrb_t         strb,
  output logic             pinHigh,
  output logic             acceptOpen,
  output logic             reqHeld,
  output logic             leadDone,
  output logic             lastXfer,
  output logic             cntZeroIn,
  output logic             xferDone
);

  localparam int LEAD_W = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;

  logic [SYNC_STAGES-1:0] syncReg;
  logic [CNT_W-1:0]       remCnt;
  logic [LEAD_W-1:0]      leadCnt;
  logic                   seenHigh;

  // Synchronizer chain; reset to the idle (high) pin level.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[0] <= 1'b1;
        else       syncReg[0] <= pinN;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[g] <= 1'b1;
        else       syncReg[g] <= syncReg[g-1];
      end
    end
  end

  assign pinHigh   = syncReg[SYNC_STAGES-1];
  assign cntZeroIn = (cntIn == '0);
  assign lastXfer  = (remCnt == CNT_W'(1));
  assign leadDone  = (leadCnt == LEAD_W'(LEAD_CYC - 1));

  // Remaining transfer count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              remCnt <= '0;
    else if (strb.loadCnt)  remCnt <= cntIn;
    else if (strb.endWrite) remCnt <= remCnt - CNT_W'(1);
    else if (strb.shutdown) remCnt <= '0;
  end

  // Lead-time counter between latch and bus phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              leadCnt <= '0;
    else if (strb.latchReq) leadCnt <= '0;
    else if (strb.leadTick) leadCnt <= leadCnt + LEAD_W'(1);
  end

  // Rearm tracker: high level seen since the last accepted low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            seenHigh <= 1'b0;
    else if (strb.openAccept || strb.latchReq) seenHigh <= 1'b0;
    else if (strb.sampleHigh && pinHigh)  seenHigh <= 1'b1;
  end

  // Acceptance window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                acceptOpen <= 1'b0;
    else if (strb.shutdown)                   acceptOpen <= 1'b0;
    else if (strb.openAccept)                 acceptOpen <= 1'b1;
    else if (strb.latchReq)                   acceptOpen <= 1'b0;
    else if (strb.endWrite)                   acceptOpen <= seenHigh | pinHigh;
    else if (strb.reopenIfHigh && pinHigh)    acceptOpen <= 1'b1;
  end

  // Held request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               reqHeld <= 1'b0;
    else if (strb.shutdown || strb.clrReq)   reqHeld <= 1'b0;
    else if (strb.latchReq)                  reqHeld <= 1'b1;
  end

  // Completion pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xferDone <= 1'b0;
    else       xferDone <= strb.shutdown;
  end

endmodule

// File: rtl/dma_acc_control.sv
module dma_acc_control
  import dma_acc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enWrStrobe,
  input  logic     enWrData,
  input  logic     busGrant,
  input  logic     cycleDone,
  input  logic     pinHigh,
  input  logic     acceptOpen,
  input  logic     leadDone,
  input  logic     lastXfer,
  input  logic     cntZeroIn,
  output ctlStrb_t strb,
  output logic     busReq,
  output logic     cycWrite
);

  accState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (enWrStrobe && !enWrData) begin
      if (state != ST_IDLE) begin
        strb.shutdown = 1'b1;
        nextState     = ST_IDLE;
      end
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (enWrStrobe) begin
            if (cntZeroIn) begin
              strb.shutdown = 1'b1;
            end else begin
              strb.loadCnt    = 1'b1;
              strb.openAccept = 1'b1;
              nextState       = ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (acceptOpen && !pinHigh) begin
            strb.latchReq = 1'b1;
            nextState     = ST_LEAD;
          end else if (!acceptOpen) begin
            strb.reopenIfHigh = 1'b1;
          end
        end
        ST_LEAD: begin
          if (leadDone) begin
            strb.clrReq = 1'b1;
            nextState   = ST_GRANT;
          end else begin
            strb.leadTick = 1'b1;
          end
        end
        ST_GRANT: begin
          strb.sampleHigh = 1'b1;
          if (busGrant) nextState = ST_READ;
        end
        ST_READ: begin
          strb.sampleHigh = 1'b1;
          if (cycleDone) nextState = ST_WRITE;
        end
        ST_WRITE: begin
          strb.sampleHigh = 1'b1;
          if (cycleDone) begin
            if (lastXfer) begin
              strb.shutdown = 1'b1;
              nextState     = ST_IDLE;
            end else begin
              strb.endWrite = 1'b1;
              nextState     = ST_ARMED;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign busReq   = (state == ST_GRANT) || (state == ST_READ) || (state == ST_WRITE);
  assign cycWrite = (state == ST_WRITE);

endmodule

// File: rtl/dma_req_accept.sv
module dma_req_accept
  import dma_acc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int LEAD_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqPinN,
  input  logic             enWrStrobe,
  input  logic             enWrData,
  input  logic [CNT_W-1:0] xferCount,
  input  logic             busGrant,
  input  logic             cycleDone,
  output logic             reqHeld,
  output logic             busReq,
  output logic             cycWrite,
  output logic             acceptOpen,
  output logic             xferDone
);

  ctlStrb_t strb;
  logic     pinHigh;
  logic     leadDone;
  logic     lastXfer;
  logic     cntZeroIn;

  dma_acc_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enWrStrobe (enWrStrobe),
    .enWrData   (enWrData),
    .busGrant   (busGrant),
    .cycleDone  (cycleDone),
    .pinHigh    (pinHigh),
    .acceptOpen (acceptOpen),
    .leadDone   (leadDone),
    .lastXfer   (lastXfer),
    .cntZeroIn  (cntZeroIn),
    .strb       (strb),
    .busReq     (busReq),
    .cycWrite   (cycWrite)
  );

  dma_acc_datapath #(
    .CNT_W       (CNT_W),
    .LEAD_CYC    (LEAD_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinN       (reqPinN),
    .cntIn      (xferCount),
    .strb       (strb),
    .pinHigh    (pinHigh),
    .acceptOpen (acceptOpen),
    .reqHeld    (reqHeld),
    .leadDone   (leadDone),
    .lastXfer   (lastXfer),
    .cntZeroIn  (cntZeroIn),
    .xferDone   (xferDone)
  );

endmodule

// File: rtl/dma_req_accept_chk.sv
module dma_req_accept_chk (
  input logic clk,
  input logic rstN,
  input logic reqHeld,
  input logic busReq,
  input logic cycWrite,
  input logic acceptOpen,
  input logic xferDone
);

  // R4: the bus phase starts only after at least three cycles of held request
  a_r4_lead_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> ($past(reqHeld) && $past(reqHeld, 2) && $past(reqHeld, 3)));

  // R3: latching a request closes acceptance on the same edge
  a_r3_latch_closes: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqHeld) |-> !acceptOpen);

  // R5: write follows a read cycle inside one bus phase
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cycWrite) |-> ($past(busReq) && !$past(cycWrite)));

  // R5: write indication only inside a bus phase
  a_r5_write_in_bus: assert property (@(posedge clk) disable iff (!rstN)
    cycWrite |-> busReq);

  // R7: acceptance stays shut while the bus phase runs
  a_r7_closed_in_bus: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !acceptOpen);

  // R4: held request and bus request never overlap
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    reqHeld |-> !busReq);

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R9: completion leaves nothing held and nothing open
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (!reqHeld && !busReq && !acceptOpen));

endmodule

bind dma_req_accept dma_req_accept_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqHeld    (reqHeld),
  .busReq     (busReq),
  .cycWrite   (cycWrite),
  .acceptOpen (acceptOpen),
  .xferDone   (xferDone)
);

// File: tb/tb_dma_req_accept.sv
module tb_dma_req_accept;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqPinN = 1'b1;
  logic             enWrStrobe = 1'b0;
  logic             enWrData = 1'b0;
  logic [CNT_W-1:0] xferCount = '0;
  logic             busGrant = 1'b0;
  logic             cycleDone = 1'b0;
  logic             reqHeld, busReq, cycWrite, acceptOpen, xferDone;
  logic             stubOn = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_req_accept #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqPinN(reqPinN),
    .enWrStrobe(enWrStrobe), .enWrData(enWrData), .xferCount(xferCount),
    .busGrant(busGrant), .cycleDone(cycleDone),
    .reqHeld(reqHeld), .busReq(busReq), .cycWrite(cycWrite),
    .acceptOpen(acceptOpen), .xferDone(xferDone)
  );

  // Bus stub: grant follows request, one done per cycle with a gap between.
  always @(negedge clk) begin
    if (stubOn) begin
      busGrant  <= busReq;
      cycleDone <= busReq && busGrant && !cycleDone;
    end else begin
      busGrant  <= 1'b0;
      cycleDone <= 1'b0;
    end
  end

  // Scenario table: {transfer count, pin returns high during bus phase}
  localparam logic [8:0] VEC [4] = '{
    {8'd3, 1'b1}, {8'd2, 1'b0}, {8'd1, 1'b1}, {8'd3, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enableWrite(input logic data, input logic [CNT_W-1:0] cnt);
    enWrStrobe = 1'b1; enWrData = data; xferCount = cnt;
    @(negedge clk);
    enWrStrobe = 1'b0; enWrData = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    step(3);
    // R1: reset state
    chk({reqHeld, busReq, cycWrite, acceptOpen, xferDone} == 5'b0, "R1 reset outputs",
        {reqHeld, busReq, cycWrite, acceptOpen, xferDone}, 0);
    rstN = 1'b1;
    step(2);
    // R1: lows ignored while idle
    reqPinN = 1'b0;
    step(8);
    chk(!reqHeld && !busReq, "R1 idle ignores pin", {reqHeld, busReq}, 0);
    reqPinN = 1'b1;
    step(4);

    // Table-driven transfer scenarios
    foreach (VEC[v]) begin
      automatic int cnt   = int'(VEC[v][8:1]);
      automatic bit rearm = VEC[v][0];
      reqPinN = 1'b1;
      step(4);
      chk(!acceptOpen, "R2 closed before enable", acceptOpen, 0);
      enableWrite(1'b1, CNT_W'(cnt));
      chk(acceptOpen, "R2 open after enable write", acceptOpen, 1);
      for (int t = 0; t < cnt; t++) begin
        automatic bit last = (t == cnt - 1);
        reqPinN = 1'b0;
        step(2);
        chk(!reqHeld, "R3 no latch before sync delay", reqHeld, 0);
        step(1);
        chk(reqHeld && !acceptOpen, "R3 latch on third edge", {reqHeld, acceptOpen}, 2);
        step(2);
        chk(reqHeld && !busReq, "R4 held during lead", {reqHeld, busReq}, 2);
        step(1);
        chk(!reqHeld && busReq && !cycWrite, "R4 bus phase after lead",
            {reqHeld, busReq, cycWrite}, 2);
        if (rearm) reqPinN = 1'b1;
        for (int i = 0; i < 20 && busReq && !cycWrite; i++) @(negedge clk);
        chk(busReq && cycWrite, "R5 write follows read", {busReq, cycWrite}, 3);
        for (int i = 0; i < 20 && busReq; i++) @(negedge clk);
        chk(!busReq, "R5 bus released", busReq, 0);
        if (last) begin
          chk(xferDone && !acceptOpen, "R8 done pulse at count end",
              {xferDone, acceptOpen}, 2);
          step(1);
          chk(!xferDone, "R8 done pulse one cycle", xferDone, 0);
          reqPinN = 1'b1; step(4); reqPinN = 1'b0; step(8);
          chk(!reqHeld && !busReq, "R8 ignores pin after end", {reqHeld, busReq}, 0);
          reqPinN = 1'b1;
        end else if (rearm) begin
          chk(acceptOpen && !xferDone, "R6 reopens right after write",
              {acceptOpen, xferDone}, 2);
        end else begin
          chk(!acceptOpen, "R7 stays closed without high", acceptOpen, 0);
          step(8);
          chk(!reqHeld && !busReq && !acceptOpen, "R7 held low starts nothing",
              {reqHeld, busReq, acceptOpen}, 0);
          reqPinN = 1'b1;
          step(4);
          chk(acceptOpen, "R7 reopens on high sample", acceptOpen, 1);
        end
      end
    end

    // R10: zero count
    reqPinN = 1'b1;
    step(3);
    enableWrite(1'b1, '0);
    chk(xferDone && !acceptOpen, "R10 zero count pulses done", {xferDone, acceptOpen}, 2);
    step(1);
    chk(!xferDone && !acceptOpen, "R10 stays idle", {xferDone, acceptOpen}, 0);

    // R9: disable during lead
    enableWrite(1'b1, 8'd5);
    reqPinN = 1'b0;
    step(4);
    chk(reqHeld, "R9 request held before disable", reqHeld, 1);
    enableWrite(1'b0, 8'd5);
    chk(!reqHeld && !acceptOpen && xferDone, "R9 disable clears and pulses",
        {reqHeld, acceptOpen, xferDone}, 1);
    step(1);
    chk(!xferDone, "R9 pulse one cycle", xferDone, 0);
    step(6);
    chk(!busReq && !reqHeld, "R9 no bus phase after disable", {busReq, reqHeld}, 0);
    reqPinN = 1'b1;
    step(3);

    // R5: withheld grant keeps request up, no read progress
    stubOn = 1'b0;
    enableWrite(1'b1, 8'd1);
    reqPinN = 1'b0;
    for (int i = 0; i < 20 && !busReq; i++) @(negedge clk);
    step(5);
    chk(busReq && !cycWrite, "R5 waits for grant", {busReq, cycWrite}, 2);
    stubOn = 1'b1;
    for (int i = 0; i < 20 && busReq; i++) @(negedge clk);
    chk(!busReq && xferDone, "R5 completes after grant", {busReq, xferDone}, 1);
    reqPinN = 1'b1;
    step(3);

    summary();
  end

endmodule